// File: doc/BRIEF.md
# Microphone clock enable sequencer

This block decides which of four digital-microphone bit clocks are switched on. Each microphone interface carries a stereo pair, so the block serves up to eight channels at once. Software writes a channel count and a four-entry pair-to-clock table through a small configuration port, then pulses start. The block turns on one clock per cycle, walking the table from entry 0, until it has turned on one clock for each requested pair. A stop pulse turns every clock off at once.

The table lets a board whose microphones are wired in a non-default order work unchanged. A table that names the same clock twice is reported as invalid, and the block then uses the identity order. Channel counts that are not a whole number of pairs within range are rejected with an error flag. While the block is running, configuration writes are ignored, so the clocks never change under a live capture.

Top module: `mic_clk_seq`

## Requirements
- R1: After reset, `clk_en_o` is 0, `busy_o` is 0, both error flags are 0, the stored channel count is 0, and the stored table is the identity order (entry k holds k).
- R2: With the identity table, a run with N channels (N = 2, 4, 6 or 8) ends with clock enables 0 to N/2-1 set and all others clear.
- R3: The table is `cfg_order_i`, with entry k at bits [2k+1:2k] holding a clock index 0 to 3. The table {0,3,2,1} (value 0x6C) turns on clock 0, then 3, then 2, then 1 as the pairs are added.
- R4: A run with N channels uses only table entries 0 to N/2-1. The remaining entries have no effect on the enables.
- R5: A write whose count is odd or above 8 sets `cnt_err_o` and keeps the previously stored count. A write with a valid count stores it and clears `cnt_err_o`. The table part of the write is stored in both cases.
- R6: A stored table in which any index appears twice drives `order_bad_o` high, and runs then use the identity order.
- R7: Sampling `start_i` while idle (and `stop_i` low) sets `busy_o` with all enables still clear. At each later edge, the enable named by the next table entry is set, one per edge, until N/2 enables are on. Enables never drop while running.
- R8: Sampling `stop_i` while running clears all enables and `busy_o` at that same edge. Stop takes priority over start.
- R9: While `busy_o` is high, configuration writes change neither the flags nor the stored count or table. The next run after a stop uses the earlier configuration.
- R10: A start with a stored count of 0 sets `busy_o` and leaves every enable clear. A start while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe (honoured only when idle) |
| cfg_chan_i | input | 4 | Requested channel count |
| cfg_order_i | input | 8 | Pair-to-clock table, entry k at bits [2k+1:2k] |
| start_i | input | 1 | Start the enable sequence |
| stop_i | input | 1 | Clear all enables and return to idle |
| clk_en_o | output | 4 | Per-interface clock enable |
| busy_o | output | 1 | Sequencer is running |
| cnt_err_o | output | 1 | Last accepted write carried an invalid count |
| order_bad_o | output | 1 | Stored table has a repeated index |

## Verification
The bench builds the block with its default of four interfaces, which gives a 4-bit count field and a 2-bit index per table entry. Every count from 0 up through the out-of-range values 10 and above can therefore be written, and every permutation and duplicate pattern of the table can be reached. The bench exercises the identity order, the reversed-tail order, a duplicated table, odd and oversized counts, and writes and starts issued mid-run. A behavioural model follows the block edge by edge, so ramp order and stop timing are checked on every cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs #(
  parameter int NUM_IF = 4,
  parameter int CHAN_W = 4,
  parameter int IDX_W  = 2,
  localparam int ORD_W = NUM_IF * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [ORD_W-1:0]  order_i,
  output logic [CHAN_W-1:0] chan_q_o,
  output logic [ORD_W-1:0]  order_q_o,
  output logic              cnt_err_o
);
  localparam logic [CHAN_W:0] MAX_CHAN = (CHAN_W+1)'(2 * NUM_IF);

  logic [ORD_W-1:0] order_rst;
  logic             chan_ok;

  for (genvar k = 0; k < NUM_IF; k++) begin : g_rst_ord
    assign order_rst[k*IDX_W +: IDX_W] = IDX_W'(k);
  end

  assign chan_ok = !chan_i[0] && ({1'b0, chan_i} <= MAX_CHAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q_o  <= '0;
      order_q_o <= order_rst;
      cnt_err_o <= 1'b0;
    end else if (wr_i) begin
      order_q_o <= order_i;
      cnt_err_o <= !chan_ok;
      if (chan_ok) chan_q_o <= chan_i;
    end
  end
endmodule

// File: rtl/mcs_order_map.sv
module mcs_order_map #(
  parameter int NUM_IF = 4,
  parameter int IDX_W  = 2,
  localparam int ORD_W = NUM_IF * IDX_W
) (
  input  logic [ORD_W-1:0] order_i,
  output logic [ORD_W-1:0] eff_order_o,
  output logic             bad_o
);
  logic [NUM_IF-1:0] range_bad;

  for (genvar k = 0; k < NUM_IF; k++) begin : g_rng
    assign range_bad[k] = {1'b0, order_i[k*IDX_W +: IDX_W]} >= (IDX_W+1)'(NUM_IF);
  end

  always_comb begin
    bad_o = |range_bad;
    for (int i = 0; i < NUM_IF; i++) begin
      for (int j = i + 1; j < NUM_IF; j++) begin
        if (order_i[i*IDX_W +: IDX_W] == order_i[j*IDX_W +: IDX_W]) bad_o = 1'b1;
      end
    end
  end

  // invalid table falls back to identity order
  for (genvar k = 0; k < NUM_IF; k++) begin : g_eff
    assign eff_order_o[k*IDX_W +: IDX_W] = bad_o ? IDX_W'(k) : order_i[k*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/mcs_ramp.sv
module mcs_ramp
  import mcs_pkg::*;
#(
  parameter int NUM_IF = 4,
  parameter int CHAN_W = 4,
  parameter int IDX_W  = 2,
  localparam int ORD_W = NUM_IF * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CHAN_W-1:0] pairs_i,
  input  logic [ORD_W-1:0]  eff_order_i,
  output logic [NUM_IF-1:0] en_o,
  output logic              busy_o
);
  seq_state_e        st_q;
  logic [CHAN_W-1:0] step_q;
  logic [IDX_W-1:0]  sel;
  logic [NUM_IF-1:0] sel_dec;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_IF; k++) begin
      if (step_q == CHAN_W'(k)) sel = eff_order_i[k*IDX_W +: IDX_W];
    end
  end

  assign sel_dec = NUM_IF'(1) << sel;
  assign busy_o  = (st_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      en_o   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i && !stop_i) begin
            st_q   <= ST_RUN;
            step_q <= '0;
          end
        end
        ST_RUN: begin
          if (stop_i) begin
            st_q <= ST_IDLE;
            en_o <= '0;
          end else if (step_q < pairs_i) begin
            en_o   <= en_o | sel_dec;
            step_q <= step_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mic_clk_seq.sv
module mic_clk_seq #(
  parameter int NUM_IF = 4,
  localparam int IDX_W  = $clog2(NUM_IF),
  localparam int CHAN_W = $clog2(2 * NUM_IF + 1),
  localparam int ORD_W  = NUM_IF * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CHAN_W-1:0] cfg_chan_i,
  input  logic [ORD_W-1:0]  cfg_order_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [NUM_IF-1:0] clk_en_o,
  output logic              busy_o,
  output logic              cnt_err_o,
  output logic              order_bad_o
);
  logic [CHAN_W-1:0] chan_q;
  logic [ORD_W-1:0]  order_q;
  logic [ORD_W-1:0]  eff_order;

  mcs_cfg_regs #(.NUM_IF(NUM_IF), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i && !busy_o),
    .chan_i    (cfg_chan_i),
    .order_i   (cfg_order_i),
    .chan_q_o  (chan_q),
    .order_q_o (order_q),
    .cnt_err_o (cnt_err_o)
  );

  mcs_order_map #(.NUM_IF(NUM_IF), .IDX_W(IDX_W)) i_map (
    .order_i     (order_q),
    .eff_order_o (eff_order),
    .bad_o       (order_bad_o)
  );

  mcs_ramp #(.NUM_IF(NUM_IF), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) i_ramp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .pairs_i     (chan_q >> 1),
    .eff_order_i (eff_order),
    .en_o        (clk_en_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/mcs_chk.sv
module mcs_chk #(
  parameter int NUM_IF = 4,
  parameter int CHAN_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [CHAN_W-1:0] cfg_chan_i,
  input logic              start_i,
  input logic              stop_i,
  input logic [NUM_IF-1:0] clk_en_o,
  input logic              busy_o,
  input logic              cnt_err_o,
  input logic              order_bad_o
);
  p_idle_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> clk_en_o == '0);

  p_bad_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cfg_wr_i && (cfg_chan_i[0] || cfg_chan_i > CHAN_W'(2 * NUM_IF))) |=> cnt_err_o);

  p_start_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !stop_i) |=> (busy_o && clk_en_o == '0));

  p_one_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $countones(clk_en_o & ~$past(clk_en_o)) <= 1);

  p_no_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !stop_i) |=> ((clk_en_o & $past(clk_en_o)) == $past(clk_en_o)));

  p_stop_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i) |=> (!busy_o && clk_en_o == '0));

  p_run_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(cnt_err_o) && $stable(order_bad_o)));
endmodule

bind mic_clk_seq mcs_chk #(.NUM_IF(NUM_IF), .CHAN_W(CHAN_W)) i_mcs_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_chan_i  (cfg_chan_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .clk_en_o    (clk_en_o),
  .busy_o      (busy_o),
  .cnt_err_o   (cnt_err_o),
  .order_bad_o (order_bad_o)
);

// File: tb/test_mic_clk_seq.sv
module test_mic_clk_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_chan = '0;
  logic [7:0] cfg_order = '0;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic [3:0] en;
  logic       busy, cnt_err, order_bad;

  int vecs = 0;
  int errs = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_chan, m_step;
  int m_tab[4];
  bit m_bad, m_err, m_busy;
  bit [3:0] m_en;

  always #2.5 clk = ~clk;

  mic_clk_seq i_mic_clk_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_chan_i(cfg_chan),
    .cfg_order_i(cfg_order), .start_i(start), .stop_i(stop),
    .clk_en_o(en), .busy_o(busy), .cnt_err_o(cnt_err), .order_bad_o(order_bad)
  );

  function automatic bit has_dup(int t[4]);
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (t[i] == t[j]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chan = 0; m_step = 0; m_bad = 0; m_err = 0; m_busy = 0; m_en = '0;
      for (int k = 0; k < 4; k++) m_tab[k] = k;
    end else if (!m_busy) begin
      if (cfg_wr) begin
        for (int k = 0; k < 4; k++) m_tab[k] = int'(cfg_order[2*k +: 2]);
        m_bad = has_dup(m_tab);
        if (cfg_chan % 2 == 0 && cfg_chan <= 8) begin m_chan = int'(cfg_chan); m_err = 0; end
        else m_err = 1;
      end
      if (start && !stop) begin m_busy = 1; m_step = 0; end
    end else if (stop) begin
      m_busy = 0; m_en = '0;
    end else if (m_step < m_chan / 2) begin
      m_en[m_bad ? m_step : m_tab[m_step]] = 1'b1;
      m_step++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vecs++;
      if (en !== m_en || busy !== m_busy || cnt_err !== m_err || order_bad !== m_bad) begin
        errs++;
        $display("FAIL %s model: got en=%b busy=%b err=%b bad=%b exp en=%b busy=%b err=%b bad=%b",
                 cur_req, en, busy, cnt_err, order_bad, m_en, m_busy, m_err, m_bad);
      end
    end
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [3:0] ch, logic [7:0] ord);
    @(negedge clk); cfg_wr = 1'b1; cfg_chan = ch; cfg_order = ord;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    cur_req = "R1";
    check("R1 en", 8'(en), 8'h0);
    check("R1 flags", {5'b0, busy, cnt_err, order_bad}, 8'h0);

    // R2 identity order, 8 channels, with R7 ramp walk
    cur_req = "R2";
    write_cfg(4'd8, 8'hE4);
    pulse_start();
    check("R7 start clear", {3'b0, busy, en}, 8'h10);
    cyc(1); check("R7 step0", 8'(en), 8'h1);
    cyc(1); check("R7 step1", 8'(en), 8'h3);
    cyc(3); check("R2 eight", 8'(en), 8'hF);
    cur_req = "R8";
    pulse_stop();
    check("R8 stop", {3'b0, busy, en}, 8'h00);

    cur_req = "R2";
    write_cfg(4'd4, 8'hE4);
    pulse_start(); cyc(4);
    check("R2 four", 8'(en), 8'h3);
    pulse_stop();

    // R3 custom order {0,3,2,1}
    cur_req = "R3";
    write_cfg(4'd8, 8'h6C);
    pulse_start();
    cyc(1); check("R3 first", 8'(en), 8'h1);
    cyc(1); check("R3 second", 8'(en), 8'h9);
    cyc(1); check("R3 third", 8'(en), 8'hD);
    cyc(1); check("R3 fourth", 8'(en), 8'hF);
    pulse_stop();

    // R4 only leading entries used
    cur_req = "R4";
    write_cfg(4'd2, 8'h6C);
    pulse_start(); cyc(4);
    check("R4 two", 8'(en), 8'h1);
    pulse_stop();
    write_cfg(4'd6, 8'h6C);
    pulse_start(); cyc(5);
    check("R4 six", 8'(en), 8'hD);
    pulse_stop();

    // R5 invalid counts keep previous count
    cur_req = "R5";
    write_cfg(4'd3, 8'hE4);
    check("R5 odd flag", {7'b0, cnt_err}, 8'h1);
    pulse_start(); cyc(5);
    check("R5 kept six", 8'(en), 8'h7);
    pulse_stop();
    write_cfg(4'd10, 8'hE4);
    check("R5 big flag", {7'b0, cnt_err}, 8'h1);
    write_cfg(4'd2, 8'hE4);
    check("R5 clear", {7'b0, cnt_err}, 8'h0);

    // R6 duplicate table {1,1,2,3}
    cur_req = "R6";
    write_cfg(4'd4, 8'hE5);
    check("R6 flag", {7'b0, order_bad}, 8'h1);
    pulse_start(); cyc(4);
    check("R6 fallback", 8'(en), 8'h3);
    pulse_stop();

    // R9 writes while running are ignored
    cur_req = "R9";
    write_cfg(4'd2, 8'h6C);
    pulse_start(); cyc(3);
    write_cfg(4'd5, 8'hE5);
    check("R9 flags", {6'b0, cnt_err, order_bad}, 8'h0);
    pulse_stop();
    pulse_start(); cyc(4);
    check("R9 old cfg", {3'b0, busy, en}, 8'h11);
    // R10 start while running has no effect
    cur_req = "R10";
    pulse_start(); cyc(2);
    check("R10 restart", {3'b0, busy, en}, 8'h11);
    pulse_stop();

    // R10 zero channels
    write_cfg(4'd0, 8'hE4);
    pulse_start(); cyc(4);
    check("R10 zero", {3'b0, busy, en}, 8'h10);
    // R8 stop beats start
    cur_req = "R8";
    @(negedge clk); stop = 1'b1; start = 1'b1;
    @(negedge clk); stop = 1'b0; start = 1'b0;
    check("R8 priority", {3'b0, busy, en}, 8'h00);
    cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule